// File: doc/BRIEF.md
# Fixed-Modulus Iterated Squarer

The block raises a starting value to the power 2^n modulo a modulus fixed at elaboration, one squaring per clock cycle, as the sequential core of a delay-function evaluator. Between iterations the value stays in redundant form, as a vector of coefficients of `COEF_W` bits with guard bits. The square is built from AND-gate partial products summed per column, followed by one carry-propagate add. Every bit of the square above the low `LOW_W` bits gates its own elaboration-time constant, equal to 2^weight mod M, into the per-coefficient accumulators. The carry of each accumulator above `COEF_W` bits then moves one coefficient up. This keeps the state bounded below 2^(LOW_W+GUARD_W) without a full reduction on each iteration.

A caller pulses `start_i` with an initial value and an iteration count. The block squares `count_i` times. It then flattens the coefficients and runs a restoring normalisation that tries subtracting the modulus shifted by GUARD_W down to 0. It then presents the fully reduced residue on `y_o` with a one-cycle `done_o`. `y_o` holds its value until the next result. With the defaults the modulus is M = 0xFFFF_FFFF_FFFF_FFC5, split into four 16-bit coefficients with 8 guard bits.

Top module: `msq_core`

## Requirements
- R1: After a run with count n, `y_o` equals x^(2^n) mod M, where x is the `x_i` value latched at the start and M = 0xFFFF_FFFF_FFFF_FFC5.
- R2: With count zero, `y_o` equals x mod M, and this holds also for x ≥ M.
- R3: `done_o` is high for exactly one cycle per run, and `busy_o` is low in that cycle. `busy_o` is high from the cycle after an accepted start until `done_o` is raised.
- R4: `done_o` is seen after the (n+11)th rising edge, counting the edge that accepts `start_i` as the first (defaults: 8 guard bits give 9 normalisation steps).
- R5: `start_i` while `busy_o` is high is ignored. This includes a start on the edge that raises `done_o`. The result and the latency are those of the first request.
- R6: A start sampled in the cycle in which `done_o` is high is accepted and begins a new run.
- R7: Whenever `done_o` is high, `y_o` < M. `y_o` changes only at an edge that raises `done_o`.
- R8: After reset, `busy_o`, `done_o` and `y_o` are all zero.
- R9: Results stay exact when every input coefficient is all ones, so that carries move in every coefficient, and for x = M−1 and x = M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a run; sampled when idle |
| x_i | input | MOD_W | Initial value |
| count_i | input | CNT_W | Number of squarings |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle result strobe |
| y_o | output | MOD_W | Reduced result, held |

## Verification
Two events can share a cycle. One is a new request. The other is the completion of the final normalisation step, which raises `done_o`. The bench provokes this in two ways. It raises `start_i` so that it is sampled on the very edge that raises `done_o`; that request must be ignored. It also raises `start_i` in the cycle in which `done_o` is already high; that request must be accepted. In both cases the bench judges the outcome by the value of the next result and by its exact latency, against residues computed by repeated wide-integer squaring.

// File: rtl/msq_pkg.sv
package msq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SQR  = 2'd1,
    ST_NORM = 2'd2
  } msq_state_e;
endpackage

// File: rtl/msq_square.sv
// Squares a redundant coefficient vector: AND partial products, one-level column sums, one CPA.
module msq_square #(
  parameter int NUM_COEF = 4,
  parameter int COEF_W   = 16,
  parameter int CW       = 24,
  parameter int SW       = 144
) (
  input  logic [NUM_COEF-1:0][CW-1:0] coef_i,
  output logic [SW-1:0]               sq_o
);
  localparam int PW   = 2 * CW;
  localparam int NCOL = 2 * NUM_COEF - 1;
  localparam int COLW = PW + $clog2(NUM_COEF) + 1;

  function automatic logic [PW-1:0] and_mul(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [PW-1:0] acc;
    acc = '0;
    for (int t = 0; t < CW; t++) acc += {{CW{1'b0}}, b & {CW{a[t]}}} << t;
    return acc;
  endfunction

  logic [PW-1:0]   pp  [NUM_COEF][NUM_COEF];
  logic [COLW-1:0] col [NCOL];

  for (genvar i = 0; i < NUM_COEF; i++) begin : g_row
    for (genvar j = 0; j < NUM_COEF; j++) begin : g_pp
      assign pp[i][j] = and_mul(coef_i[i], coef_i[j]);
    end
  end

  for (genvar k = 0; k < NCOL; k++) begin : g_col
    always_comb begin
      col[k] = '0;
      for (int i = 0; i < NUM_COEF; i++) begin
        if (k >= i && k - i < NUM_COEF) col[k] += COLW'(pp[i][k-i]);
      end
    end
  end

  always_comb begin
    sq_o = '0;
    for (int k = 0; k < NCOL; k++) sq_o += SW'(col[k]) << (COEF_W * k);
  end
endmodule

// File: rtl/msq_reduce.sv
// Folds square bits above LOW_W through 1-bit gated residue constants, then moves carries one coefficient up.
module msq_reduce #(
  parameter int              MOD_W    = 64,
  parameter logic [MOD_W-1:0] MODULUS = 64'hFFFF_FFFF_FFFF_FFC5,
  parameter int              NUM_COEF = 4,
  parameter int              COEF_W   = 16,
  parameter int              CW       = 24,
  parameter int              SW       = 144
) (
  input  logic [SW-1:0]               sq_i,
  output logic [NUM_COEF-1:0][CW-1:0] coef_o
);
  localparam int LOW_W = NUM_COEF * COEF_W;
  localparam int H     = SW - LOW_W;
  localparam int AW    = COEF_W + $clog2(H + 1);

  // Entry b holds 2^(LOW_W+b) mod MODULUS.
  function automatic logic [H*LOW_W-1:0] gen_rc();
    logic [MOD_W:0]       r;
    logic [H*LOW_W-1:0]   tbl;
    r   = (MOD_W+1)'(1);
    tbl = '0;
    for (int b = 0; b < LOW_W + H; b++) begin
      if (b >= LOW_W) tbl[(b-LOW_W)*LOW_W +: LOW_W] = LOW_W'(r);
      r = r << 1;
      if (r >= {1'b0, MODULUS}) r = r - {1'b0, MODULUS};
    end
    return tbl;
  endfunction

  localparam logic [H*LOW_W-1:0] RC = gen_rc();

  logic [AW-1:0] acc [NUM_COEF];

  // Constant-zero residue bits fold away; ones leave one AND gate per bit.
  for (genvar k = 0; k < NUM_COEF; k++) begin : g_acc
    always_comb begin
      acc[k] = AW'(sq_i[COEF_W*k +: COEF_W]);
      for (int b = 0; b < H; b++)
        acc[k] += AW'(RC[b*LOW_W + COEF_W*k +: COEF_W] & {COEF_W{sq_i[LOW_W+b]}});
    end
  end

  for (genvar k = 0; k < NUM_COEF; k++) begin : g_mv
    logic [CW-1:0] keep, cin;
    if (k == NUM_COEF - 1) begin : g_top
      assign keep = CW'(acc[k]);
    end else begin : g_low
      assign keep = CW'(acc[k][COEF_W-1:0]);
    end
    if (k == 0) begin : g_first
      assign cin = '0;
    end else begin : g_next
      assign cin = CW'(acc[k-1][AW-1:COEF_W]);
    end
    assign coef_o[k] = keep + cin;
  end
endmodule

// File: rtl/msq_norm.sv
// Flattens the coefficients and performs one restoring step against MODULUS << shift_i.
module msq_norm #(
  parameter int              MOD_W    = 64,
  parameter logic [MOD_W-1:0] MODULUS = 64'hFFFF_FFFF_FFFF_FFC5,
  parameter int              NUM_COEF = 4,
  parameter int              COEF_W   = 16,
  parameter int              CW       = 24,
  parameter int              VW       = 72,
  parameter int              SH_W     = 4
) (
  input  logic [NUM_COEF-1:0][CW-1:0] coef_i,
  input  logic [VW-1:0]               val_i,
  input  logic [SH_W-1:0]             shift_i,
  output logic [VW-1:0]               flat_o,
  output logic [VW-1:0]               val_o
);
  logic [VW:0] sub;

  always_comb begin
    flat_o = '0;
    for (int k = 0; k < NUM_COEF; k++) flat_o += VW'(coef_i[k]) << (COEF_W * k);
  end

  always_comb begin
    sub   = (VW+1)'(MODULUS) << shift_i;
    val_o = val_i;
    if ({1'b0, val_i} >= sub) val_o = VW'({1'b0, val_i} - sub);
  end
endmodule

// File: rtl/msq_core.sv
module msq_core
  import msq_pkg::*;
#(
  parameter int              MOD_W    = 64,
  parameter logic [MOD_W-1:0] MODULUS = 64'hFFFF_FFFF_FFFF_FFC5,
  parameter int              COEF_W   = 16,
  parameter int              GUARD_W  = 8,
  parameter int              CNT_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [MOD_W-1:0] x_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [MOD_W-1:0] y_o
);
  localparam int NUM_COEF = (MOD_W + COEF_W - 1) / COEF_W;
  localparam int LOW_W    = NUM_COEF * COEF_W;
  localparam int CW       = COEF_W + GUARD_W;
  localparam int VW       = LOW_W + GUARD_W;
  localparam int SW       = 2 * VW;
  localparam int SMAX     = VW - MOD_W;
  localparam int SH_W     = $clog2(SMAX + 1) > 0 ? $clog2(SMAX + 1) : 1;

  msq_state_e                 st_q;
  logic [NUM_COEF-1:0][CW-1:0] coef_q, coef_nx, coef_ld;
  logic [CNT_W-1:0]           cnt_q;
  logic [VW-1:0]              val_q, val_nx, flat;
  logic [SH_W-1:0]            sh_q;
  logic [SW-1:0]              sq;
  logic [LOW_W-1:0]           x_ext;

  assign x_ext = LOW_W'(x_i);
  for (genvar k = 0; k < NUM_COEF; k++) begin : g_ld
    assign coef_ld[k] = CW'(x_ext[COEF_W*k +: COEF_W]);
  end

  msq_square #(.NUM_COEF(NUM_COEF), .COEF_W(COEF_W), .CW(CW), .SW(SW)) u_sq (
    .coef_i (coef_q),
    .sq_o   (sq)
  );

  msq_reduce #(.MOD_W(MOD_W), .MODULUS(MODULUS), .NUM_COEF(NUM_COEF),
               .COEF_W(COEF_W), .CW(CW), .SW(SW)) u_red (
    .sq_i   (sq),
    .coef_o (coef_nx)
  );

  msq_norm #(.MOD_W(MOD_W), .MODULUS(MODULUS), .NUM_COEF(NUM_COEF),
             .COEF_W(COEF_W), .CW(CW), .VW(VW), .SH_W(SH_W)) u_norm (
    .coef_i  (coef_q),
    .val_i   (val_q),
    .shift_i (sh_q),
    .flat_o  (flat),
    .val_o   (val_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      coef_q <= '0;
      cnt_q  <= '0;
      val_q  <= '0;
      sh_q   <= '0;
      y_o    <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          coef_q <= coef_ld;
          cnt_q  <= count_i;
          st_q   <= ST_SQR;
        end
        ST_SQR: if (cnt_q == '0) begin
          val_q <= flat;
          sh_q  <= SH_W'(SMAX);
          st_q  <= ST_NORM;
        end else begin
          coef_q <= coef_nx;
          cnt_q  <= cnt_q - 1'b1;
        end
        ST_NORM: begin
          val_q <= val_nx;
          if (sh_q == '0) begin
            y_o    <= MOD_W'(val_nx);
            done_o <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            sh_q <= sh_q - 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
endmodule

// File: rtl/msq_core_chk.sv
module msq_core_chk
  import msq_pkg::*;
#(
  parameter int              MOD_W   = 64,
  parameter logic [MOD_W-1:0] MODULUS = 64'hFFFF_FFFF_FFFF_FFC5,
  parameter int              CNT_W   = 16,
  parameter int              SH_W    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [MOD_W-1:0] y_o,
  input msq_state_e       st_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [SH_W-1:0]  sh_i
);
  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_accept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  assert_ignore_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && st_i == ST_SQR && cnt_i != '0) |=> (st_i == ST_SQR && cnt_i == $past(cnt_i) - 1'b1));
  assert_norm_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_NORM && sh_i != '0) |=> (st_i == ST_NORM && sh_i == $past(sh_i) - 1'b1));
  assert_residue_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (y_o < MODULUS));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(y_o) |-> done_o);
endmodule

bind msq_core msq_core_chk #(.MOD_W(MOD_W), .MODULUS(MODULUS), .CNT_W(CNT_W), .SH_W(SH_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .y_o     (y_o),
  .st_i    (st_q),
  .cnt_i   (cnt_q),
  .sh_i    (sh_q)
);

// File: tb/sim_msq_core.sv
`timescale 1ns/1ps
module sim_msq_core;
  localparam logic [63:0] M = 64'hFFFF_FFFF_FFFF_FFC5;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] x_i = '0;
  logic [15:0] count_i = '0;
  logic        busy_o, done_o;
  logic [63:0] y_o;
  int          tests = 0;
  int          fails = 0;

  always #2 clk = ~clk;

  msq_core u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .x_i(x_i),
    .count_i(count_i), .busy_o(busy_o), .done_o(done_o), .y_o(y_o)
  );

  function automatic logic [63:0] ref_pow(input logic [63:0] x, input int n);
    logic [127:0] r;
    r = {64'd0, x} % {64'd0, M};
    for (int i = 0; i < n; i++) r = (r * r) % {64'd0, M};
    return r[63:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One run; gap idle cycles first, optional foreign start at loop cycle inj.
  task automatic run(input logic [63:0] x, input int n, input int gap, input int inj, input string tag);
    logic [63:0] exp;
    int cyc;
    repeat (gap) @(negedge clk);
    if (gap == 0) chk(done_o === 1'b1, "R6 start coincides with done", 64'(done_o), 64'd1);
    exp = ref_pow(x, n);
    start_i = 1'b1; x_i = x; count_i = 16'(n);
    @(posedge clk);
    cyc = 1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R3 busy after accept", 64'(busy_o), 64'd1);
    while (done_o !== 1'b1 && cyc < 400) begin
      if (inj != 0 && cyc == inj) begin
        start_i = 1'b1; x_i = ~x; count_i = 16'd3;
      end else start_i = 1'b0;
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    chk(y_o === exp, tag, y_o, exp);
    chk(cyc == n + 11, "R4 latency", 64'(cyc), 64'(n + 11));
    chk(busy_o === 1'b0, "R3 busy low at done", 64'(busy_o), 64'd0);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] held, xs;
    repeat (3) @(negedge clk);
    chk(busy_o === 1'b0, "R8 busy reset", 64'(busy_o), 64'd0);
    chk(done_o === 1'b0, "R8 done reset", 64'(done_o), 64'd0);
    chk(y_o === 64'd0, "R8 y reset", y_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 / R9 boundaries with zero count
    run(64'd0, 0, 1, 0, "R2 x=0");
    run(64'd1, 0, 1, 0, "R2 x=1");
    run(M - 64'd1, 0, 1, 0, "R9 x=M-1");
    run(M, 0, 1, 0, "R9 x=M");
    run(M + 64'd7, 0, 1, 0, "R2 x above M");
    run(64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 0, "R9 all-ones");

    // R9 carry stress with iterations
    run(64'hFFFF_FFFF_FFFF_FFFF, 5, 1, 0, "R9 all-ones squared");
    run(M - 64'd1, 3, 1, 0, "R9 M-1 squared");

    // R1 count sweep over several values
    for (int n = 0; n < 16; n++) begin
      run(64'h0123_4567_89AB_CDEF, n, 1, 0, "R1 sweep a");
      run({$urandom, $urandom}, n, 0, 0, "R1 sweep random");
    end
    for (int t = 0; t < 30; t++)
      run({$urandom, $urandom}, int'($urandom % 40), int'($urandom % 3), 0, "R1 random");

    // R5 foreign starts: early in squaring, in normalisation, on the done edge
    run(64'hDEAD_BEEF_0BAD_F00D, 20, 1, 3, "R5 start during squaring");
    run(64'h1357_9BDF_2468_ACE0, 6, 1, 12, "R5 start during normalisation");
    run(64'h0F0F_F0F0_1234_8765, 9, 1, 19, "R5 start on done edge");

    // R6 back to back, R7 hold
    run(64'h7777_0000_FFFF_1111, 2, 0, 0, "R6 back-to-back result");
    held = y_o;
    repeat (12) @(negedge clk);
    chk(y_o === held, "R7 y held while idle", y_o, held);
    chk(y_o < M, "R7 y below modulus", y_o, M);
    xs = 64'h5555_AAAA_5555_AAAA;
    start_i = 1'b1; x_i = xs; count_i = 16'd4;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    chk(y_o === held, "R7 y held while busy", y_o, held);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule